// File: doc/BRIEF.md
# Four-Channel External Interrupt Controller

This block turns four asynchronous input pins into four interrupt request lines. Each pin first passes through a two-flop synchronizer. It then reaches a per-channel detector that is set to trigger either on a level or on an edge, and either on the low or high level (falling or rising edge). When a detector reports its condition, the channel's sticky flag is set, and the flag drives that channel's interrupt request output directly.

Software uses a single-cycle 32-bit register bus. There are three registers: a flag register, a mode register and a polarity register. Bit n of each register belongs to channel n. A flag is cleared by writing a one to its bit. In level mode the flag comes straight back while the pin stays at its active level, so the handler keeps being re-entered. In edge mode each qualifying transition produces exactly one flag event.

Each channel detector is a two-state machine that records the last synchronized pin value. It has the states PIN_LOW and PIN_HIGH. The transition named *rise* goes from PIN_LOW to PIN_HIGH when the synchronized pin reads 1. The transition named *fall* goes from PIN_HIGH to PIN_LOW when it reads 0. In every other case the machine holds its state. An edge event is a *rise* with polarity 1 or a *fall* with polarity 0. A level event occurs in every cycle in which the synchronized pin equals the polarity bit.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, the flag, mode and polarity registers read 0, and every `irq_out` bit is 0.
- R2: The flag register is at offset 0x0, the mode register at 0x8 and the polarity register at 0xC. Each holds channels 0..3 in bits 0..3. Bits 31..4 read as 0. Offset 0x4 reads as 0.
- R3: With mode bit 0 (level), a flag sets while the synchronized pin equals the polarity bit. Polarity 0 means active low and polarity 1 means active high.
- R4: With mode bit 1 (edge), polarity 0 sets the flag on a falling edge and polarity 1 sets it on a rising edge. Each transition sets the flag once, however long the new level is held.
- R5: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A flag stays set after its cause goes away until it is cleared.
- R6: In level mode, clearing a flag while the pin is still active leaves the flag set. The flag sets again on the same edge as the clear.
- R7: When a set event and a write-one clear hit the same flag bit on the same clock edge, the flag ends set.
- R8: A pin change is reflected on `irq_out` at the third rising clock edge after the change, and not before.
- R9: Each `irq_out` bit equals the matching flag bit that is read back at offset 0x0.
- R10: Channels are independent. A condition on one channel sets no other channel's flag.
- R11: In edge mode, neither the opposite transition nor a held level sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 4 | Asynchronous interrupt input pins, one per channel |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_out | output | 4 | Interrupt request lines, one per channel |

## Verification
The assertions check the following on every cycle: a flag that is set cannot be lost, a flag only rises when its detector reports an event, cleared bits that saw no event drop, a level-mode channel whose pin is active is flagged on the next edge, an edge-mode channel never produces events on back-to-back cycles, and reserved read bits stay zero. The bench's scenarios show the rest. It sweeps every channel through all four mode and polarity settings and checks the three-edge latency, the single event per edge, how opposite transitions and held levels behave, and the re-set after a clear in level mode. It also lines up a clear with a set event on one edge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_FLAG = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MODE = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_POL  = 4'hC;

    // Detector state: last synchronized pin value
    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    // Mode bit encoding
    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_EDGE  = 1'b1
    } det_mode_e;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp,       // synchronized pin
    input  det_mode_e mode,
    input  logic      pol,
    output logic      evt
);

    pin_state_e state_q, state_d;
    logic       rise, fall;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_HIGH;
        else        state_q <= state_d;
    end

    // Transitions: rise, fall, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (smp)  state_d = PIN_HIGH;
            PIN_HIGH: if (!smp) state_d = PIN_LOW;
            default:            state_d = state_q;
        endcase
    end

    // Outputs
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            PIN_LOW:  rise = smp;
            PIN_HIGH: fall = !smp;
            default: begin
                rise = 1'b0;
                fall = 1'b0;
            end
        endcase
        if (mode == DET_EDGE) evt = pol ? rise : fall;
        else                  evt = (smp == pol);
    end

    // R4 / R11: an edge event cannot repeat on the next cycle with unchanged polarity
    assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_EDGE && evt) |=> !(mode == DET_EDGE && evt && $stable(pol)));

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] set_vec,
    output logic [NUM_CH-1:0] flag_o,
    output logic [NUM_CH-1:0] mode_o,
    output logic [NUM_CH-1:0] pol_o
);

    localparam int PAD_W = DATA_W - NUM_CH;

    logic [NUM_CH-1:0] flag_q, mode_q, pol_q;
    logic [NUM_CH-1:0] clr_vec;
    logic              wr_flag, wr_mode, wr_pol;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_CH];

    assign wr_flag = bus_sel && bus_wr && (bus_addr == OFS_FLAG);
    assign wr_mode = bus_sel && bus_wr && (bus_addr == OFS_MODE);
    assign wr_pol  = bus_sel && bus_wr && (bus_addr == OFS_POL);
    assign clr_vec = wr_flag ? bus_wdata[NUM_CH-1:0] : '0;

    // Flags: set has priority over write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            pol_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata[NUM_CH-1:0];
            if (wr_pol)  pol_q  <= bus_wdata[NUM_CH-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_FLAG: bus_rdata = {{PAD_W{1'b0}}, flag_q};
                OFS_MODE: bus_rdata = {{PAD_W{1'b0}}, mode_q};
                OFS_POL:  bus_rdata = {{PAD_W{1'b0}}, pol_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign flag_o = flag_q;
    assign mode_o = mode_q;
    assign pol_o  = pol_q;

    // R7: a set event always leaves the flag set, whatever is written
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

    // R5: cleared bits without a set event drop
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((flag_q & $past(clr_vec & ~set_vec)) == '0));

    // R3 / R4: a flag only rises when the detector reported an event
    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));

    // R2: reserved bits read zero
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |-> (bus_rdata[DATA_W-1:NUM_CH] == '0));

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_out
);

    logic [NUM_CH-1:0] pin_smp;
    logic [NUM_CH-1:0] evt_vec;
    logic [NUM_CH-1:0] flag_vec, mode_vec, pol_vec;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            eirq_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_in[c]),
                .q     (pin_smp[c])
            );

            eirq_detect u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .smp   (pin_smp[c]),
                .mode  (det_mode_e'(mode_vec[c])),
                .pol   (pol_vec[c]),
                .evt   (evt_vec[c])
            );

            // R6: an active level in level mode is flagged on the next edge
            assert_level_refire_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!mode_vec[c] && (pin_smp[c] == pol_vec[c])) |=> irq_out[c]);
        end
    endgenerate

    eirq_regs #(
        .NUM_CH (NUM_CH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .set_vec   (evt_vec),
        .flag_o    (flag_vec),
        .mode_o    (mode_vec),
        .pol_o     (pol_vec)
    );

    assign irq_out = flag_vec;

endmodule

// File: tb/eirq_ctrl_tb.sv
`timescale 1ns/1ps
module eirq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_in = 4'hF;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    eirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        chk("R1 irq at reset", {28'h0, irq_out}, 32'h0);
        rst_n = 1'b1;
        idle(3);
        bus_read(4'h0, rd); chk("R1 flag reset", rd, 32'h0);
        bus_read(4'h8, rd); chk("R1 mode reset", rd, 32'h0);
        bus_read(4'hC, rd); chk("R1 pol reset", rd, 32'h0);
        chk("R1 irq idle", {28'h0, irq_out}, 32'h0);

        // R2: register map and reserved bits
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h8, rd); chk("R2 mode reserved", rd, 32'h0000_000F);
        bus_write(4'hC, 32'hFFFF_FFF5);
        bus_read(4'hC, rd); chk("R2 pol reserved", rd, 32'h0000_0005);
        bus_read(4'h4, rd); chk("R2 unmapped offset", rd, 32'h0);
        bus_write(4'h8, 32'h0);
        bus_write(4'hC, 32'h0);

        // Sweep: each channel, each mode, each polarity
        for (int ch = 0; ch < 4; ch++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                logic m, p;
                logic [3:0] one;
                m = cfg[1]; p = cfg[0];
                one = 4'b0001 << ch;
                pin_in = 4'hF;
                bus_write(4'h8, {28'h0, m ? one : 4'h0});
                bus_write(4'hC, {28'h0, p ? one : 4'h0});
                @(negedge clk);
                pin_in[ch] = ~p;          // inactive level
                idle(4);
                bus_write(4'h0, 32'hF);
                idle(1);
                chk($sformatf("R10 quiet ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, 32'h0);

                // Activate; R8 latency
                @(negedge clk);
                pin_in[ch] = p;
                @(posedge clk); @(posedge clk); @(negedge clk);
                chk($sformatf("R8 early ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, 32'h0);
                @(posedge clk); @(negedge clk);
                chk($sformatf("R3 R4 R10 set ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, {28'h0, one});
                bus_read(4'h0, rd);
                chk($sformatf("R9 readback ch%0d cfg%0d", ch, cfg), rd, {28'h0, irq_out});

                if (m) begin
                    bus_write(4'h0, 32'h0);
                    chk($sformatf("R5 write zero ch%0d", ch), {28'h0, irq_out}, {28'h0, one});
                    bus_write(4'h0, {28'h0, one});
                    chk($sformatf("R5 clear ch%0d", ch), {28'h0, irq_out}, 32'h0);
                    idle(6);
                    chk($sformatf("R4 one event ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, 32'h0);
                    pin_in[ch] = ~p;
                    idle(6);
                    chk($sformatf("R11 opposite edge ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, 32'h0);
                end else begin
                    bus_write(4'h0, {28'h0, one});
                    chk($sformatf("R6 refire ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, {28'h0, one});
                    pin_in[ch] = ~p;
                    idle(5);
                    chk($sformatf("R5 sticky ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, {28'h0, one});
                    bus_write(4'h0, {28'h0, one});
                    idle(3);
                    chk($sformatf("R5 level clear ch%0d cfg%0d", ch, cfg), {28'h0, irq_out}, 32'h0);
                end
            end
        end

        // R7: clear lands on the same edge as a new falling-edge set on channel 2
        pin_in = 4'hF;
        bus_write(4'h8, 32'h4);
        bus_write(4'hC, 32'h0);
        idle(4);
        bus_write(4'h0, 32'hF);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(5);
        chk("R7 first event", {28'h0, irq_out}, 32'h4);
        pin_in[2] = 1'b1;
        idle(5);
        @(negedge clk); pin_in[2] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h4;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        chk("R7 set beats clear", {28'h0, irq_out}, 32'h4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule